// File: doc/BRIEF.md
# Variable-Length Command Stream Decoder

This block takes a byte stream from a host link and cuts it into commands whose length depends on the opcode: one, two, three, four or sixty-four bytes. Each finished command becomes single-cycle strobes with their operands. The strobes drive an 8-bit address/data bus to an attached logic array, supply setpoint and pin-layout outputs, and a configuration-data stream. A 64-byte status buffer gathers array read results and a fixed device identifier. A status-request command streams the whole buffer back out.

Opcode 0x0E is a prefix. Its second byte picks a sub-function. Any opcode or sub-function outside the known set sets a sticky error flag. The flag halts decoding until it is cleared. Input is a valid/ready byte stream. The status readout is a valid/ready byte stream with a last marker.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset, err is 0, every strobe and st_valid are 0, in_ready is 1, and all 64 status bytes read as zero.
- R2: Opcodes 0x00, 0x0D, 0x19 and 0x34 are one-byte commands that raise no strobe and change no status byte.
- R3: Opcode 0x01 (one byte) raises bus_rd for one cycle, in the cycle after the opcode is accepted. At the end of that cycle, bus_rdata is stored into status byte 0.
- R4: Opcode 0x0A takes an address byte and then a data byte. bus_ale pulses with bus_data equal to the address in the cycle after the address is accepted. bus_wr pulses with bus_data equal to the data byte in the cycle after the data byte is accepted.
- R5: Opcode 0x0B takes one address byte. bus_ale pulses with the address in the cycle after it is accepted, and in_ready is low during that cycle. bus_rd pulses in the next cycle, and bus_rdata is stored into status byte 0 at its end.
- R6: Opcode 0x10 takes one operand byte. bus_wr pulses with bus_data equal to that operand in the cycle after it is accepted, and bus_ale stays low.
- R7: Opcode 0x07 starts a readout of exactly 64 status bytes in index order starting at byte 0. st_last is high only on byte 63. st_data and st_last hold while st_ready is low. in_ready stays low until the last byte is taken.
- R8: Four-byte command 0x0E 0x11 x x writes device-identifier byte i into status byte i for i from 0 to 15, where byte 0 is DEV_ID[127:120]. Status bytes 16 to 63 are left as they were.
- R9: 0x0E 0x12 v x and 0x0E 0x13 v x pulse volt_stb in the cycle after the fourth byte is accepted. volt_val equals v, and volt_aux is 0 for 0x12 and 1 for 0x13.
- R10: 0x0E 0x14/0x15/0x16 v x pulse lay_stb in the cycle after the fourth byte is accepted. lay_val equals v, and lay_kind is 0, 1 or 2 respectively.
- R11: 0x0E 0x21 x x pulses cfg_start. 0x0E 0x22 x x is followed by 60 payload bytes, and each one appears on cfg_data with cfg_valid in the cycle after it is accepted. The byte after the 60th is decoded as an opcode.
- R12: Opcode 0x1B (one byte) pulses flush. Sub-functions 0x1F, 0x20, 0x25 and 0x28 consume four bytes with no strobe.
- R13: Any other opcode, or any other 0x0E sub-function byte, sets err in the cycle after it is accepted. While err is set, in_ready is 0 and no strobe is raised. err_clear clears err, except when an offending byte is accepted in the same cycle; then err stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Decoder takes a byte this cycle |
| err_clear | input | 1 | Clears the error flag |
| err | output | 1 | Sticky unknown-command flag |
| bus_data | output | 8 | Array address/data bus |
| bus_ale | output | 1 | Address latch strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Array read data, sampled while bus_rd is high |
| volt_stb | output | 1 | Supply setpoint strobe |
| volt_aux | output | 1 | 0 programming supply, 1 auxiliary supply |
| volt_val | output | 8 | Setpoint in tenths of a volt |
| lay_stb | output | 1 | Pin-layout select strobe |
| lay_kind | output | 2 | 0 programming, 1 auxiliary, 2 ground |
| lay_val | output | 8 | Layout number |
| cfg_start | output | 1 | Begin configuration strobe |
| cfg_valid | output | 1 | Configuration byte present |
| cfg_data | output | 8 | Configuration byte |
| flush | output | 1 | Flush/commit strobe |
| st_valid | output | 1 | Status byte present |
| st_ready | input | 1 | Status consumer takes the byte |
| st_data | output | 8 | Status byte |
| st_last | output | 1 | Final status byte |

## Verification
Status byte 0 has two users: the read capture writes it, and the readout sends it out. The two can meet on one edge. This happens when opcode 0x01 is followed at once by 0x07, because the capture at the end of the bus_rd cycle lands on the same edge that starts the readout. The bench sends these two bytes back to back with the readout consumer stalling. Its reference model orders the capture before the readout, and the first streamed byte must equal bus_rdata as driven during the bus_rd cycle. A second collision is err_clear on the same edge as an offending opcode. There the flag must stay set.

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder #(
  parameter int           STAT_BYTES = 64,
  parameter int           CFG_BYTES  = 60,
  parameter logic [127:0] DEV_ID     = "CMDSTREAM-ID-v01"
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       err_clear,
  output logic       err,
  output logic [7:0] bus_data,
  output logic       bus_ale,
  output logic       bus_wr,
  output logic       bus_rd,
  input  logic [7:0] bus_rdata,
  output logic       volt_stb,
  output logic       volt_aux,
  output logic [7:0] volt_val,
  output logic       lay_stb,
  output logic [1:0] lay_kind,
  output logic [7:0] lay_val,
  output logic       cfg_start,
  output logic       cfg_valid,
  output logic [7:0] cfg_data,
  output logic       flush,
  output logic       st_valid,
  input  logic       st_ready,
  output logic [7:0] st_data,
  output logic       st_last
);
  localparam int IW       = $clog2(STAT_BYTES);
  localparam int LASTPOS  = CFG_BYTES + 3;
  localparam int PW       = $clog2(LASTPOS + 1);
  localparam int ID_BYTES = 16;

  logic [7:0]    stat [STAT_BYTES];
  logic [IW-1:0] sidx;
  logic [PW-1:0] pos;
  logic [7:0]    op, sub, arg;
  logic          busy, rd_pend;

  wire acc = in_valid & in_ready;
  assign in_ready = ~err & ~busy & ~rd_pend;
  assign st_valid = busy;
  assign st_data  = stat[sidx];
  assign st_last  = busy & (sidx == IW'(STAT_BYTES - 1));

  function automatic logic sub_ok(input logic [7:0] s);
    case (s)
      8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
      8'h1F, 8'h20, 8'h21, 8'h22, 8'h25, 8'h28: sub_ok = 1'b1;
      default:                                  sub_ok = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAT_BYTES; i++) stat[i] <= '0;
    end else begin
      if (bus_rd) stat[0] <= bus_rdata;
      if (acc && pos == PW'(3) && sub == 8'h11)
        for (int i = 0; i < ID_BYTES; i++) stat[i] <= DEV_ID[127 - 8*i -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= 1'b0; busy <= 1'b0; rd_pend <= 1'b0; sidx <= '0; pos <= '0;
      op <= '0; sub <= '0; arg <= '0; bus_data <= '0;
      bus_ale <= 1'b0; bus_wr <= 1'b0; bus_rd <= 1'b0;
      volt_stb <= 1'b0; volt_aux <= 1'b0; volt_val <= '0;
      lay_stb <= 1'b0; lay_kind <= '0; lay_val <= '0;
      cfg_start <= 1'b0; cfg_valid <= 1'b0; cfg_data <= '0; flush <= 1'b0;
    end else begin
      bus_ale <= 1'b0; bus_wr <= 1'b0; volt_stb <= 1'b0; lay_stb <= 1'b0;
      cfg_start <= 1'b0; cfg_valid <= 1'b0; flush <= 1'b0;
      bus_rd  <= rd_pend;
      rd_pend <= 1'b0;
      if (st_valid && st_ready) begin
        if (st_last) busy <= 1'b0;
        else         sidx <= sidx + IW'(1);
      end
      if (err_clear) err <= 1'b0;
      if (acc) begin
        if (pos == '0) begin
          op <= in_data;
          case (in_data)
            8'h00, 8'h0D, 8'h19, 8'h34: ;
            8'h01: bus_rd <= 1'b1;
            8'h07: begin busy <= 1'b1; sidx <= '0; end
            8'h1B: flush <= 1'b1;
            8'h0A, 8'h0B, 8'h10, 8'h0E: pos <= PW'(1);
            default: err <= 1'b1;
          endcase
        end else if (pos == PW'(1)) begin
          pos <= '0;
          case (op)
            8'h0A: begin bus_ale <= 1'b1; bus_data <= in_data; pos <= PW'(2); end
            8'h0B: begin bus_ale <= 1'b1; bus_data <= in_data; rd_pend <= 1'b1; end
            8'h10: begin bus_wr <= 1'b1; bus_data <= in_data; end
            default:
              if (sub_ok(in_data)) begin sub <= in_data; pos <= PW'(2); end
              else err <= 1'b1;
          endcase
        end else if (pos == PW'(2)) begin
          if (op == 8'h0A) begin
            bus_wr <= 1'b1; bus_data <= in_data; pos <= '0;
          end else begin
            arg <= in_data; pos <= PW'(3);
          end
        end else if (pos == PW'(3)) begin
          pos <= '0;
          case (sub)
            8'h12, 8'h13: begin volt_stb <= 1'b1; volt_aux <= sub[0]; volt_val <= arg; end
            8'h14, 8'h15, 8'h16: begin lay_stb <= 1'b1; lay_kind <= sub[1:0]; lay_val <= arg; end
            8'h21: cfg_start <= 1'b1;
            8'h22: pos <= PW'(4);
            default: ;
          endcase
        end else begin
          cfg_valid <= 1'b1;
          cfg_data  <= in_data;
          pos <= (pos == PW'(LASTPOS)) ? '0 : pos + PW'(1);
        end
      end
    end
  end

  a_r3_bus_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_ale, bus_wr, bus_rd}));

  a_r5_read_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale && op == 8'h0B) |=> bus_rd);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));

  a_r11_cfg_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $past(in_valid && in_ready));

  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clear) |=> err);

  a_r13_mute: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !(bus_ale || bus_wr || volt_stb || lay_stb || cfg_start || cfg_valid || flush));
endmodule

// File: tb/cmd_stream_decoder_tb_top.sv
module cmd_stream_decoder_tb_top;
  localparam logic [127:0] ID = "CMDSTREAM-ID-v01";

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, err_clear = 1'b0, st_ready = 1'b1;
  logic [7:0] in_data = '0, bus_rdata = '0;
  logic in_ready, err, bus_ale, bus_wr, bus_rd, volt_stb, volt_aux, lay_stb;
  logic cfg_start, cfg_valid, flush, st_valid, st_last;
  logic [7:0] bus_data, volt_val, lay_val, cfg_data, st_data;
  logic [1:0] lay_kind;

  cmd_stream_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .err_clear(err_clear), .err(err), .bus_data(bus_data), .bus_ale(bus_ale), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .volt_stb(volt_stb), .volt_aux(volt_aux),
    .volt_val(volt_val), .lay_stb(lay_stb), .lay_kind(lay_kind), .lay_val(lay_val),
    .cfg_start(cfg_start), .cfg_valid(cfg_valid), .cfg_data(cfg_data), .flush(flush),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_last(st_last));

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  bit stall = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] q[$];
  logic [7:0] m_stat [64];
  bit m_err, m_busy, m_rdnext;
  int m_idx;
  bit e_rd, e_ale, e_wr, e_volt, e_vaux, e_lay, e_cfgs, e_cfgv, e_flush;
  logic [7:0] e_bus, e_vval, e_lval, e_cfgd;
  logic [1:0] e_lkind;

  always @(posedge clk) begin : model
    bit rdy;
    int n;
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 64; i++) m_stat[i] = 8'h00;
      m_err = 0; m_busy = 0; m_rdnext = 0; m_idx = 0;
      e_rd = 0; e_ale = 0; e_wr = 0; e_volt = 0; e_vaux = 0; e_lay = 0;
      e_cfgs = 0; e_cfgv = 0; e_flush = 0;
      e_bus = 0; e_vval = 0; e_lval = 0; e_cfgd = 0; e_lkind = 0;
    end else begin
      rdy = !m_err && !m_busy && !m_rdnext;
      if (e_rd) m_stat[0] = bus_rdata;
      e_rd = m_rdnext; m_rdnext = 0;
      e_ale = 0; e_wr = 0; e_volt = 0; e_lay = 0; e_cfgs = 0; e_cfgv = 0; e_flush = 0;
      if (m_busy && st_ready) begin
        if (m_idx == 63) m_busy = 0; else m_idx++;
      end
      if (err_clear) m_err = 0;
      if (in_valid && rdy) begin
        q.push_back(in_data);
        n = q.size() - 1;
        case (q[0])
          8'h00, 8'h0D, 8'h19, 8'h34: q.delete();
          8'h01: begin e_rd = 1; q.delete(); end
          8'h07: begin m_busy = 1; m_idx = 0; q.delete(); end
          8'h1B: begin e_flush = 1; q.delete(); end
          8'h0A: if (n == 1) begin e_ale = 1; e_bus = q[1]; end
                 else if (n == 2) begin e_wr = 1; e_bus = q[2]; q.delete(); end
          8'h0B: if (n == 1) begin e_ale = 1; e_bus = q[1]; m_rdnext = 1; q.delete(); end
          8'h10: if (n == 1) begin e_wr = 1; e_bus = q[1]; q.delete(); end
          8'h0E: begin
            if (n == 1 && !(q[1] inside {8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
                                          8'h1F, 8'h20, 8'h21, 8'h22, 8'h25, 8'h28})) begin
              m_err = 1; q.delete();
            end else if (n == 3) begin
              if (q[1] == 8'h11) for (int i = 0; i < 16; i++) m_stat[i] = ID[127 - 8*i -: 8];
              if (q[1] == 8'h12 || q[1] == 8'h13) begin e_volt = 1; e_vaux = (q[1] == 8'h13); e_vval = q[2]; end
              if (q[1] >= 8'h14 && q[1] <= 8'h16) begin e_lay = 1; e_lkind = 2'(q[1] - 8'h14); e_lval = q[2]; end
              if (q[1] == 8'h21) e_cfgs = 1;
              if (q[1] != 8'h22) q.delete();
            end else if (n >= 4) begin
              e_cfgv = 1; e_cfgd = in_data;
              if (n == 63) q.delete();
            end
          end
          default: begin m_err = 1; q.delete(); end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R13", "in_ready", in_ready, int'(!m_err && !m_busy && !m_rdnext));
      chk("R13", "err", err, m_err);
      chk("R3", "bus_rd", bus_rd, e_rd);
      chk("R4", "bus_ale", bus_ale, e_ale);
      chk("R6", "bus_wr", bus_wr, e_wr);
      chk("R4", "bus_data", bus_data, e_bus);
      chk("R7", "st_valid", st_valid, m_busy);
      if (m_busy) begin
        chk("R7", "st_data", st_data, m_stat[m_idx]);
        chk("R7", "st_last", st_last, int'(m_idx == 63));
      end
      chk("R9", "volt_stb", volt_stb, e_volt);
      if (e_volt) begin chk("R9", "volt_aux", volt_aux, e_vaux); chk("R9", "volt_val", volt_val, e_vval); end
      chk("R10", "lay_stb", lay_stb, e_lay);
      if (e_lay) begin chk("R10", "lay_kind", lay_kind, e_lkind); chk("R10", "lay_val", lay_val, e_lval); end
      chk("R11", "cfg_start", cfg_start, e_cfgs);
      chk("R11", "cfg_valid", cfg_valid, e_cfgv);
      if (e_cfgv) chk("R11", "cfg_data", cfg_data, e_cfgd);
      chk("R12", "flush", flush, e_flush);
      if (bus_ale || bus_wr || bus_rd || volt_stb || lay_stb || cfg_start || cfg_valid || flush) pulses++;
    end
    bus_rdata <= 8'(cyc * 13 + 5);
    st_ready  <= stall ? (cyc % 3 != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R13 watchdog actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    bit r;
    in_valid = 1'b1; in_data = b;
    forever begin
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cmd4(input logic [7:0] s, input logic [7:0] v);
    send(8'h0E); send(s); send(v); send(8'h00);
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "err", err, 0);
    chk("R1", "st_valid", st_valid, 0);
    chk("R1", "strobes", int'(bus_ale | bus_wr | bus_rd | volt_stb | lay_stb | cfg_valid | flush), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h07); idle(70);                        // R1 status zeros via readout
    p0 = pulses;
    send(8'h00); send(8'h0D); send(8'h19); send(8'h34); idle(4);
    chk("R2", "no-op strobe count", pulses - p0, 0);
    send(8'h0A); send(8'h5A); send(8'hC3);        // R4
    send(8'h10); send(8'h77);                     // R6
    send(8'h0B); send(8'h21);                     // R5
    send(8'h01); idle(3);                         // R3
    stall = 1'b1;
    send(8'h01); send(8'h07); idle(110);          // capture meets readout start
    stall = 1'b0;
    cmd4(8'h11, 8'h00); send(8'h07); idle(70);    // R8
    cmd4(8'h12, 8'h33); cmd4(8'h13, 8'h50);       // R9
    cmd4(8'h14, 8'h02); cmd4(8'h15, 8'h07); cmd4(8'h16, 8'h01); // R10
    cmd4(8'h21, 8'h00);                           // R11
    send(8'h0E); send(8'h22); send(8'h00); send(8'h00);
    for (int i = 0; i < 60; i++) begin
      send(8'(i * 3 + 1));
      if (i % 7 == 0) idle(1);
    end
    send(8'h1B);                                  // R12
    cmd4(8'h1F, 8'h01); cmd4(8'h20, 8'h02); cmd4(8'h25, 8'h03); cmd4(8'h28, 8'h04);
    idle(3);
    send(8'h42); idle(2);                         // R13 unknown opcode
    poke(8'h0A); poke(8'h01); poke(8'h02); idle(2);
    chk("R13", "err held", err, 1);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
    idle(2);
    send(8'h0E); send(8'h99); idle(3);           // R13 bad sub-function
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
    idle(2);
    in_valid = 1'b1; in_data = 8'h55; err_clear = 1'b1;   // R13 clear meets offence
    @(negedge clk);
    in_valid = 1'b0; err_clear = 1'b0;
    idle(2);
    chk("R13", "err after clear+offence", err, 1);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
    send(8'h0A); send(8'h10); send(8'h20);
    send(8'h01); send(8'h07); idle(80);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule